// File: doc/BRIEF.md
# Atomic 16-bit Register Access Bridge

This block sits between an 8-bit synchronous bus and a 16-bit counter with a 16-bit preload value. It lets software read and write the two 16-bit quantities one byte at a time without ever seeing or committing a torn value. One internal 8-bit buffer, the low-byte holding register, serves both directions.

On the write side, a low-byte write only fills the holding register. A high-byte write then commits the new high byte and the held low byte to the preload output as one 16-bit word. It also raises a one-cycle load pulse, so the downstream counter can decide when to take the value.

On the read side, a high-byte read returns the live counter high byte. In the same cycle it copies the live counter low byte into the holding register. A later low-byte read returns that snapshot, so the two halves always come from the same counter value.

There is no state machine in the usual sense. The only state is the holding register, the preload word and the pulse flag. A small enumerated access decoder chooses the read source for each cycle:
- `ACC_NONE`: no read strobe is active.
- `ACC_RD_HI`: a high-byte read is active. It has priority.
- `ACC_RD_LO`: only a low-byte read is active.

The decoder re-evaluates every cycle, so any access kind can follow any other in the next cycle.

Top module: `atomic16_bridge`

## Requirements
- R1: A low-byte write (`wr_lo_stb`) without a high-byte write leaves `preload_value` unchanged and produces no `preload_load` pulse. It only stores `bus_wdata` in the holding register.
- R2: A high-byte write (`wr_hi_stb`) at a clock edge makes `preload_value` equal {written byte, holding register} after that edge. The written byte is bits 15:8 and the holding register is bits 7:0.
- R3: Every high-byte write commits, including back-to-back high-byte writes with no low-byte write between them. Each one reuses the current holding register contents.
- R4: During a high-byte read (`rd_hi_stb`), `bus_rdata` shows `cnt_value[15:8]` combinationally. At the clock edge the holding register captures `cnt_value[7:0]`.
- R5: During a low-byte read (`rd_lo_stb` without `rd_hi_stb`), `bus_rdata` shows the holding register, not the live counter low byte.
- R6: Reset (`rst_n` low) clears the holding register, `preload_value` and `preload_load` to zero. A high-byte write right after reset therefore commits a low half of 0x00.
- R7: When a high-byte read and a low-byte write share a cycle, the holding register takes the written byte, not the counter snapshot.
- R8: `preload_load` is high for exactly the one cycle following each clock edge at which `wr_hi_stb` was high, and low otherwise.
- R9: When a low-byte write and a high-byte write share a cycle, the commit uses the holding register value from before that edge. The holding register then holds the newly written byte.
- R10: `bus_rdata` is 0x00 when no read strobe is active.
- R11: When both read strobes are active, the high-byte read wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wdata | input | 8 | Write data byte |
| wr_lo_stb | input | 1 | Low-byte write strobe |
| wr_hi_stb | input | 1 | High-byte write strobe (commits the word) |
| rd_lo_stb | input | 1 | Low-byte read strobe |
| rd_hi_stb | input | 1 | High-byte read strobe (snapshots the low byte) |
| bus_rdata | output | 8 | Read data byte, combinational |
| cnt_value | input | 16 | Live counter value |
| preload_value | output | 16 | Committed preload word |
| preload_load | output | 1 | One-cycle pulse after each commit |

## Verification
A corrupted holding register cannot be seen at once. It shows up at the ports only on the next low-byte read, as a wrong `bus_rdata`, or on the next high-byte write, as a wrong low half of `preload_value`. The bench therefore follows every write or snapshot with a read or commit within a cycle or two. A wrong commit or pulse is visible one cycle after the strobe edge. A wrong read source is visible in the strobe cycle itself. The bench sweeps all sixteen strobe combinations over a set of data and counter patterns, so that priority errors surface in the cycle they happen.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    // Read source selected for the current cycle
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_RD_HI = 2'd1,
        ACC_RD_LO = 2'd2
    } acc_e;

    function automatic acc_e decode_read(input logic rd_lo, input logic rd_hi);
        if (rd_hi)      return ACC_RD_HI;
        else if (rd_lo) return ACC_RD_LO;
        else            return ACC_NONE;
    endfunction

endpackage

// File: rtl/lowbyte_buf.sv
module lowbyte_buf #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              rd_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] cnt_lo,
    output logic [BYTE_W-1:0] buf_q
);

    logic [BYTE_W-1:0] buf_d;

    // Written byte has priority over the counter snapshot
    always_comb begin
        buf_d = buf_q;
        if (wr_lo)      buf_d = wdata;
        else if (rd_hi) buf_d = cnt_lo;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    AST_SNAPSHOT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi && !wr_lo) |=> buf_q == $past(cnt_lo)); // R4
    AST_WRITE_BEATS_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> buf_q == $past(wdata)); // R7
    AST_BUF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !rd_hi) |=> $stable(buf_q)); // R5

endmodule

// File: rtl/preload_commit.sv
module preload_commit #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] buf_q,
    output logic [WORD_W-1:0] preload,
    output logic              load_pulse
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preload    <= '0;
            load_pulse <= 1'b0;
        end else begin
            load_pulse <= wr_hi;
            if (wr_hi) preload <= {wdata, buf_q};
        end
    end

    AST_COMMIT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> preload == {$past(wdata), $past(buf_q)}); // R2
    AST_NO_COMMIT_WITHOUT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> $stable(preload)); // R1
    AST_PULSE_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> load_pulse); // R8
    AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> !load_pulse); // R8

endmodule

// File: rtl/read_mux.sv
module read_mux
    import bridge_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic [BYTE_W-1:0] cnt_hi,
    input  logic [BYTE_W-1:0] buf_q,
    output logic [BYTE_W-1:0] rdata
);

    acc_e acc;

    always_comb begin
        acc = decode_read(rd_lo, rd_hi);
        unique case (acc)
            ACC_RD_HI: rdata = cnt_hi;
            ACC_RD_LO: rdata = buf_q;
            ACC_NONE:  rdata = '0;
            default:   rdata = '0;
        endcase
    end

    always_comb begin
        if (!rd_lo && !rd_hi) AST_IDLE_ZERO: assert (rdata == '0); // R10
    end

endmodule

// File: rtl/atomic16_bridge.sv
module atomic16_bridge #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              wr_lo_stb,
    input  logic              wr_hi_stb,
    input  logic              rd_lo_stb,
    input  logic              rd_hi_stb,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [WORD_W-1:0] cnt_value,
    output logic [WORD_W-1:0] preload_value,
    output logic              preload_load
);

    logic [BYTE_W-1:0] hold_q;

    lowbyte_buf #(.BYTE_W(BYTE_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_lo  (wr_lo_stb),
        .rd_hi  (rd_hi_stb),
        .wdata  (bus_wdata),
        .cnt_lo (cnt_value[BYTE_W-1:0]),
        .buf_q  (hold_q)
    );

    preload_commit #(.BYTE_W(BYTE_W)) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hi      (wr_hi_stb),
        .wdata      (bus_wdata),
        .buf_q      (hold_q),
        .preload    (preload_value),
        .load_pulse (preload_load)
    );

    read_mux #(.BYTE_W(BYTE_W)) u_rd (
        .rd_lo  (rd_lo_stb),
        .rd_hi  (rd_hi_stb),
        .cnt_hi (cnt_value[WORD_W-1:BYTE_W]),
        .buf_q  (hold_q),
        .rdata  (bus_rdata)
    );

    AST_HI_READ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi_stb |-> bus_rdata == cnt_value[WORD_W-1:BYTE_W]); // R11

endmodule

// File: tb/atomic16_bridge_test.sv
module atomic16_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        wr_lo_stb = 1'b0, wr_hi_stb = 1'b0, rd_lo_stb = 1'b0, rd_hi_stb = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] cnt_value = '0;
    logic [15:0] preload_value;
    logic        preload_load;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0]  m_buf;
    logic [15:0] m_pl;

    always #5 clk = ~clk;

    atomic16_bridge uut (
        .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata),
        .wr_lo_stb(wr_lo_stb), .wr_hi_stb(wr_hi_stb),
        .rd_lo_stb(rd_lo_stb), .rd_hi_stb(rd_hi_stb),
        .bus_rdata(bus_rdata), .cnt_value(cnt_value),
        .preload_value(preload_value), .preload_load(preload_load)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One bus cycle: drive at falling edge, check read data, clock, check registered outputs
    task automatic cycle(input bit wl, input bit wh, input bit rl, input bit rh,
                         input logic [7:0] wd, input logic [15:0] cnt);
        logic [7:0] exp_rd;
        @(negedge clk);
        wr_lo_stb = wl; wr_hi_stb = wh; rd_lo_stb = rl; rd_hi_stb = rh;
        bus_wdata = wd; cnt_value = cnt;
        #1;
        exp_rd = rh ? cnt[15:8] : (rl ? m_buf : 8'h00);
        check(rh && rl ? "R11" : rh ? "R4" : rl ? "R5" : "R10", {8'h00, bus_rdata}, {8'h00, exp_rd});
        @(posedge clk);
        if (wh) m_pl = {wd, m_buf};
        if (wl)      m_buf = wd;
        else if (rh) m_buf = cnt[7:0];
        #1;
        check(wh && wl ? "R9" : wh ? "R2" : "R1", preload_value, m_pl);
        check("R8", {15'd0, preload_load}, {15'd0, wh});
        wr_lo_stb = 0; wr_hi_stb = 0; rd_lo_stb = 0; rd_hi_stb = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        m_buf = 8'h00; m_pl = 16'h0000;
        repeat (3) @(posedge clk);
        #1;
        // R6: reset state
        check("R6", preload_value, 16'h0000);
        check("R6", {15'd0, preload_load}, 16'h0000);
        check("R6", {8'h00, bus_rdata}, 16'h0000);
        @(negedge clk); rst_n = 1'b1;

        // R6: high write after reset commits low half zero
        cycle(0, 1, 0, 0, 8'hA5, 16'h0000);
        check("R6", preload_value, 16'hA500);

        // R3: back-to-back high writes reuse the buffer
        cycle(1, 0, 0, 0, 8'h3C, 16'h0000);
        cycle(0, 1, 0, 0, 8'h11, 16'h0000);
        cycle(0, 1, 0, 0, 8'h22, 16'h0000);
        check("R3", preload_value, 16'h223C);

        // R7: snapshot and low write together, write wins
        cycle(1, 0, 0, 1, 8'h77, 16'hBEEF);
        cycle(0, 0, 1, 0, 8'h00, 16'h1234);
        check("R7", {8'h00, m_buf}, 16'h0077);

        // R4/R5: snapshot then low read returns snapshot, not live counter
        cycle(0, 0, 0, 1, 8'h00, 16'hC0DE);
        cycle(0, 0, 1, 0, 8'h00, 16'hFFFF);

        // Sweep low/high write pairs (R1, R2)
        for (int v = 0; v < 256; v += 5) begin
            cycle(1, 0, 0, 0, v[7:0], 16'h0000);
            cycle(0, 1, 0, 0, ~v[7:0], 16'h0000);
            cycle(0, 0, 1, 0, 8'h00, 16'h0000);
        end

        // Sweep snapshot reads over counter patterns (R4, R5)
        for (int c = 0; c < 65536; c += 1021) begin
            cycle(0, 0, 0, 1, 8'h00, c[15:0]);
            cycle(0, 0, 1, 0, 8'h00, ~c[15:0]);
        end

        // All strobe combinations over several data/counter patterns (R9, R10, R11)
        for (int p = 0; p < 8; p++) begin
            for (int s = 0; s < 16; s++) begin
                cycle(s[0], s[1], s[2], s[3], 8'h1F * p[7:0] + 8'h03, 16'h9A5C ^ (16'h1357 * p[15:0]));
                cycle(0, 0, 1, 0, 8'h00, 16'h0F0F);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule